// File: doc/BRIEF.md
# Prefixed Block Copy Unit

This unit sits beside a stack processor and watches the instruction byte stream. A two-byte escape sequence, a fixed prefix byte followed by an extended opcode byte, selects an extended operation. The two low bits of the extended opcode say how many parameter bytes come after it. When the extended opcode is the copy operation, those bytes form a word count. The unit then moves that many words from a source address, taken from the top of the stack, to a destination address, taken from the entry below it. It does this through a simple request/acknowledge memory port, one read and then one write per word.

A mode bit in the copy opcode picks one of two behaviours. The copy can hold the core until the last word is written, or it can run behind the core while the core keeps fetching. A copy issued while a background copy is still running waits for that copy to finish. A second extended opcode returns a status word whose bit 0 shows whether a background copy is in flight.

Top module: `xop_block_copy`

## Requirements
- R1: After reset, core_hold, mem_req, stat_valid and copy_done are all low.
- R2: Bytes are consumed only when insn_valid is high and core_hold is low. Outside an escape sequence, a byte other than the prefix 0x0F starts nothing: it causes no memory request and no status pulse.
- R3: The two low bits of the extended opcode give the number of parameter bytes that follow it: 00 gives none, 01 gives one, 10 gives two and 11 gives four. The bytes are joined most significant byte first into the word count.
- R4: An extended opcode of the form 00001yxx copies the given number of words. Word i is read from source+4i and then written to destination+4i, in ascending order. The source is tos_val and the destination is nos_val, both sampled when the last byte of the instruction is consumed.
- R5: With y=0, core_hold is high from the cycle after the last instruction byte until the cycle after the final write is acknowledged.
- R6: With y=1, core_hold falls one cycle after the last instruction byte, while the copy continues on the memory port.
- R7: A copy issued while a background copy runs keeps core_hold high. Its first memory access comes only after the earlier copy has completed.
- R8: Extended opcode 0x00 produces stat_valid for exactly one cycle, in the cycle after the opcode byte is consumed. stat_word then holds bit 31 set, bits 30..1 clear, and bit 0 set only while a background copy is in flight.
- R9: A copy with a count of zero makes no memory request and produces no copy_done.
- R10: copy_done is high for one cycle, in the cycle in which the final write is acknowledged.
- R11: Any other extended opcode still consumes its parameter bytes as set by its two low bits, and has no further effect. A parameter byte equal to the prefix does not start a new sequence.
- R12: The two low address bits of the sampled source and destination are treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction byte is presented |
| insn_byte | input | 8 | Instruction byte |
| tos_val | input | ADDR_W | Top-of-stack value, the copy source |
| nos_val | input | ADDR_W | Next-of-stack value, the copy destination |
| core_hold | output | 1 | Core must stall; no byte is consumed |
| stat_valid | output | 1 | Status word is valid this cycle |
| stat_word | output | DATA_W | Status word |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack on a read |
| mem_ack | input | 1 | Access completes this cycle |
| copy_done | output | 1 | Final word of a copy has been written |

## Verification
Copies are driven with every parameter length: one, two and four count bytes. Because the two-byte count 0x0005 is used, a design that assembled bytes in the wrong order would ask for 0x0500 words and would stand out. Blocking and background copies are compared by watching core_hold and the status bit while writes are still pending. A background copy followed at once by a blocking one shows whether the second copy waits or cuts into the first. A zero count, stray bytes outside a sequence, an unknown extended opcode whose parameter bytes copy the prefix pattern, and unaligned stack addresses each test that nothing beyond the specified effect reaches the memory port or the status output.

// File: rtl/xop_pkg.sv
package xop_pkg;

   localparam logic [7:0] XOP_PREFIX   = 8'h0F;
   localparam logic [7:0] XOP_STATUS   = 8'h00;
   localparam logic [4:0] XOP_COPY_TAG = 5'b00001;

   typedef enum logic [1:0] {
      D_IDLE,
      D_EXT,
      D_PARM,
      D_LAUNCH
   } dec_st_t;

   typedef enum logic [1:0] {
      E_IDLE,
      E_RD,
      E_WR
   } eng_st_t;

   // size field -> number of trailing parameter bytes
   function automatic logic [2:0] parm_bytes(input logic [1:0] f);
      case (f)
         2'b00:   parm_bytes = 3'd0;
         2'b01:   parm_bytes = 3'd1;
         2'b10:   parm_bytes = 3'd2;
         default: parm_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/xop_decode.sv
module xop_decode
   import xop_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [7:0]        insn_byte,
   input  logic [ADDR_W-1:0] tos_val,
   input  logic [ADDR_W-1:0] nos_val,
   input  logic              hold_in,
   input  logic              eng_busy,
   input  logic              eng_bg_busy,
   output logic              launch_o,
   output logic              start_o,
   output logic [ADDR_W-1:0] pend_src,
   output logic [ADDR_W-1:0] pend_dst,
   output logic [CNT_W-1:0]  pend_cnt,
   output logic              pend_bg,
   output logic              stat_valid,
   output logic [DATA_W-1:0] stat_word
);

   dec_st_t          st;
   logic [7:0]       op_q;
   logic [2:0]       nleft;
   logic [CNT_W-1:0] cnt_q;

   logic             take;
   logic             fin;
   logic [7:0]       fin_op;
   logic [CNT_W-1:0] cnt_shift;
   logic [CNT_W-1:0] fin_cnt;
   logic             is_copy;
   logic             is_stat;

   assign take      = insn_valid && !hold_in;
   assign cnt_shift = CNT_W'({cnt_q, insn_byte});
   assign fin       = take && (((st == D_EXT) && (parm_bytes(insn_byte[1:0]) == 3'd0)) ||
                               ((st == D_PARM) && (nleft == 3'd1)));
   assign fin_op    = (st == D_EXT) ? insn_byte : op_q;
   assign fin_cnt   = (st == D_EXT) ? '0 : cnt_shift;
   assign is_copy   = (fin_op[7:3] == XOP_COPY_TAG);
   assign is_stat   = (fin_op == XOP_STATUS);

   assign launch_o  = (st == D_LAUNCH);
   assign start_o   = (st == D_LAUNCH) && !eng_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= D_IDLE;
         op_q       <= '0;
         nleft      <= '0;
         cnt_q      <= '0;
         pend_src   <= '0;
         pend_dst   <= '0;
         pend_cnt   <= '0;
         pend_bg    <= 1'b0;
         stat_valid <= 1'b0;
         stat_word  <= '0;
      end else begin
         stat_valid <= 1'b0;
         case (st)
            D_IDLE: if (take && insn_byte == XOP_PREFIX) st <= D_EXT;
            D_EXT: if (take) begin
               op_q  <= insn_byte;
               cnt_q <= '0;
               nleft <= parm_bytes(insn_byte[1:0]);
               st    <= D_PARM;
            end
            D_PARM: if (take) begin
               cnt_q <= cnt_shift;
               nleft <= nleft - 3'd1;
            end
            D_LAUNCH: if (!eng_busy) st <= D_IDLE;
            default: st <= D_IDLE;
         endcase
         if (fin) begin
            if (is_copy) begin
               pend_src <= tos_val;
               pend_dst <= nos_val;
               pend_cnt <= fin_cnt;
               pend_bg  <= fin_op[2];
               st       <= D_LAUNCH;
            end else begin
               st <= D_IDLE;
            end
            if (is_stat) begin
               stat_valid <= 1'b1;
               stat_word  <= {1'b1, {(DATA_W-2){1'b0}}, eng_bg_busy};
            end
         end
      end
   end

   // R7
   pend_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_o && eng_busy) |=> launch_o);

   // R8
   stat_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (stat_word[DATA_W-1] && (stat_word[DATA_W-2:1] == '0)));

   // R2
   stat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> $past(insn_valid));

endmodule

// File: rtl/xop_copy_engine.sv
module xop_copy_engine
   import xop_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 32,
   parameter bit ALIGN_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] st_src,
   input  logic [ADDR_W-1:0] st_dst,
   input  logic [CNT_W-1:0]  st_cnt,
   input  logic              st_bg,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              bg_busy,
   output logic              fg_busy,
   output logic              done
);

   localparam int STEP = DATA_W / 8;
   localparam int LSB  = $clog2(STEP);

   eng_st_t           st;
   logic [ADDR_W-1:0] src;
   logic [ADDR_W-1:0] dst;
   logic [CNT_W-1:0]  left;
   logic              bg;
   logic [DATA_W-1:0] buf_q;
   logic [ADDR_W-1:0] amask;
   logic              last;

   generate
      if (ALIGN_ADDR) begin : g_align
         assign amask = ~ADDR_W'((1 << LSB) - 1);
      end else begin : g_raw
         assign amask = '1;
      end
   endgenerate

   assign last      = (left == CNT_W'(1));
   assign mem_req   = (st != E_IDLE);
   assign mem_we    = (st == E_WR);
   assign mem_addr  = (st == E_WR) ? dst : src;
   assign mem_wdata = buf_q;
   assign busy      = (st != E_IDLE);
   assign bg_busy   = busy && bg;
   assign fg_busy   = busy && !bg;
   assign done      = (st == E_WR) && mem_ack && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= E_IDLE;
         src   <= '0;
         dst   <= '0;
         left  <= '0;
         bg    <= 1'b0;
         buf_q <= '0;
      end else begin
         case (st)
            E_IDLE: if (start && st_cnt != '0) begin
               src  <= st_src & amask;
               dst  <= st_dst & amask;
               left <= st_cnt;
               bg   <= st_bg;
               st   <= E_RD;
            end
            E_RD: if (mem_ack) begin
               buf_q <= mem_rdata;
               st    <= E_WR;
            end
            E_WR: if (mem_ack) begin
               src  <= src + ADDR_W'(STEP);
               dst  <= dst + ADDR_W'(STEP);
               left <= left - CNT_W'(1);
               st   <= last ? E_IDLE : E_RD;
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   // R4
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_RD && mem_ack) |=> (mem_req && mem_we));

   // R4
   src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_WR && mem_ack && !last) |=> (mem_addr == $past(src) + ADDR_W'(STEP)));

   // R9
   zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == E_IDLE && start && st_cnt == '0) |=> !mem_req);

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/xop_block_copy.sv
module xop_block_copy
   import xop_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 32,
   parameter bit ALIGN_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_valid,
   input  logic [7:0]        insn_byte,
   input  logic [ADDR_W-1:0] tos_val,
   input  logic [ADDR_W-1:0] nos_val,
   output logic              core_hold,
   output logic              stat_valid,
   output logic [DATA_W-1:0] stat_word,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic              copy_done
);

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_dw
         $error("xop_block_copy: DATA_W must be a byte multiple of at least 16");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
         $error("xop_block_copy: CNT_W must lie in 1..32");
      end
      if (ADDR_W < 4) begin : g_bad_aw
         $error("xop_block_copy: ADDR_W too small");
      end
   endgenerate

   logic              launch;
   logic              start;
   logic [ADDR_W-1:0] p_src;
   logic [ADDR_W-1:0] p_dst;
   logic [CNT_W-1:0]  p_cnt;
   logic              p_bg;
   logic              eng_busy;
   logic              eng_bg_busy;
   logic              eng_fg_busy;

   assign core_hold = launch || eng_fg_busy;

   xop_decode #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .insn_valid (insn_valid),
      .insn_byte  (insn_byte),
      .tos_val    (tos_val),
      .nos_val    (nos_val),
      .hold_in    (core_hold),
      .eng_busy   (eng_busy),
      .eng_bg_busy(eng_bg_busy),
      .launch_o   (launch),
      .start_o    (start),
      .pend_src   (p_src),
      .pend_dst   (p_dst),
      .pend_cnt   (p_cnt),
      .pend_bg    (p_bg),
      .stat_valid (stat_valid),
      .stat_word  (stat_word)
   );

   xop_copy_engine #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .ALIGN_ADDR(ALIGN_ADDR)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .st_src   (p_src),
      .st_dst   (p_dst),
      .st_cnt   (p_cnt),
      .st_bg    (p_bg),
      .mem_req  (mem_req),
      .mem_we   (mem_we),
      .mem_addr (mem_addr),
      .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata),
      .mem_ack  (mem_ack),
      .busy     (eng_busy),
      .bg_busy  (eng_bg_busy),
      .fg_busy  (eng_fg_busy),
      .done     (copy_done)
   );

   // R5
   fg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !eng_bg_busy) |-> core_hold);

endmodule

// File: tb/xop_block_copy_bench.sv
module xop_block_copy_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [7:0]  insn_byte = 8'h00;
   logic [31:0] tos_val = '0;
   logic [31:0] nos_val = '0;
   logic        core_hold;
   logic        stat_valid;
   logic [31:0] stat_word;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_ack;
   logic        copy_done;

   always #10 clk = ~clk;

   xop_block_copy u_xop_block_copy (
      .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_byte(insn_byte),
      .tos_val(tos_val), .nos_val(nos_val), .core_hold(core_hold),
      .stat_valid(stat_valid), .stat_word(stat_word), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .copy_done(copy_done)
   );

   logic [31:0] mem   [256];
   logic [31:0] ref_m [256];
   logic [63:0] exp_q [$];
   int nchk = 0;
   int nfail = 0;
   int req_cycles = 0;
   int done_cnt = 0;
   int stat_seen = 0;
   int cyc = 0;
   logic done_prev = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   // memory model: ack every second cycle of a request
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else begin
         mem_ack <= mem_req && !mem_ack;
         if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
      end
   end
   assign mem_rdata = mem[mem_addr[9:2]];

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) req_cycles++;
         if (stat_valid) stat_seen++;
         if (copy_done) begin
            done_cnt++;
            chk(!done_prev, "R10 done wider than one cycle", 32'(done_prev), 32'h0);
         end
         done_prev = copy_done;
         if (mem_req && mem_we && mem_ack) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", mem_addr, 32'h0);
            else begin
               logic [63:0] it;
               it = exp_q.pop_front();
               chk(mem_addr == it[63:32], "R4 write address", mem_addr, it[63:32]);
               chk(mem_wdata == it[31:0], "R4 write data", mem_wdata, it[31:0]);
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
         finish_run();
      end
   end

   task automatic send(input logic [7:0] b);
      insn_byte  = b;
      insn_valid = 1'b1;
      while (core_hold) @(negedge clk);
      @(negedge clk);
      insn_valid = 1'b0;
   endtask

   task automatic do_copy(input logic [31:0] src, input logic [31:0] dst,
                          input int cnt, input bit bg, input logic [1:0] sz);
      int nb;
      for (int i = 0; i < cnt; i++) begin
         logic [31:0] a, d;
         a = (src & ~32'h3) + 32'(4*i);
         d = (dst & ~32'h3) + 32'(4*i);
         ref_m[d[9:2]] = ref_m[a[9:2]];
         exp_q.push_back({d, ref_m[d[9:2]]});
      end
      nb = (sz == 2'b11) ? 4 : int'(sz);
      tos_val = src;
      nos_val = dst;
      send(8'h0F);
      send({5'b00001, bg, sz});
      for (int k = nb - 1; k >= 0; k--) send(8'(cnt >> (8*k)));
   endtask

   task automatic read_status(input logic [31:0] exp, input string tag);
      send(8'h0F);
      send(8'h00);
      chk(stat_valid == 1'b1, {tag, " status valid"}, 32'(stat_valid), 32'h1);
      chk(stat_word == exp, {tag, " status word"}, stat_word, exp);
      @(negedge clk);
      chk(stat_valid == 1'b0, "R8 status one cycle", 32'(stat_valid), 32'h0);
   endtask

   task automatic blocking(input logic [31:0] src, input logic [31:0] dst,
                           input int cnt, input logic [1:0] sz, input string tag);
      int d0;
      d0 = done_cnt;
      do_copy(src, dst, cnt, 1'b0, sz);
      chk(core_hold == 1'b1, {tag, " hold after issue"}, 32'(core_hold), 32'h1);
      while (core_hold) @(negedge clk);
      chk(exp_q.size() == 0, {tag, " hold ended before last write"}, 32'(exp_q.size()), 32'h0);
      chk(done_cnt == d0 + 1, {tag, " one done pulse"}, 32'(done_cnt), 32'(d0 + 1));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]   = (32'(i) * 32'h01010101) ^ 32'hC0DE0000;
         ref_m[i] = (32'(i) * 32'h01010101) ^ 32'hC0DE0000;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(core_hold == 1'b0, "R1 hold in reset", 32'(core_hold), 32'h0);
      chk(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 32'h0);
      chk(stat_valid == 1'b0, "R1 stat_valid in reset", 32'(stat_valid), 32'h0);
      chk(copy_done == 1'b0, "R1 done in reset", 32'(copy_done), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 idle status
      read_status(32'h8000_0000, "R8 idle");

      // R2 stray bytes outside a sequence
      begin
         int r0, s0;
         r0 = req_cycles; s0 = stat_seen;
         send(8'h08); send(8'h00); send(8'h8C);
         repeat (6) @(negedge clk);
         chk(req_cycles == r0, "R2 stray bytes made requests", 32'(req_cycles), 32'(r0));
         chk(stat_seen == s0, "R2 stray bytes made status", 32'(stat_seen), 32'(s0));
      end

      // R3 / R5 each parameter length
      blocking(32'h000, 32'h200, 3, 2'b01, "R5 R3 one-byte count");
      blocking(32'h040, 32'h280, 5, 2'b10, "R5 R3 two-byte count msb first");
      blocking(32'h080, 32'h300, 4, 2'b11, "R5 R3 four-byte count");

      // R12 unaligned stack addresses
      blocking(32'h0C3, 32'h322, 2, 2'b01, "R12 unaligned");

      // R6 background copy with status
      do_copy(32'h100, 32'h380, 10, 1'b1, 2'b01);
      @(negedge clk);
      chk(core_hold == 1'b0, "R6 hold released", 32'(core_hold), 32'h0);
      chk(exp_q.size() > 0, "R6 copy still running", 32'(exp_q.size()), 32'h1);
      read_status(32'h8000_0001, "R6 R8 busy");
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      read_status(32'h8000_0000, "R8 after background");

      // R7 new copy behind a background copy
      begin
         int d0;
         d0 = done_cnt;
         do_copy(32'h140, 32'h3C0, 6, 1'b1, 2'b01);
         @(negedge clk);
         do_copy(32'h180, 32'h3E0, 2, 1'b0, 2'b01);
         chk(core_hold == 1'b1, "R7 hold while earlier copy runs", 32'(core_hold), 32'h1);
         chk(exp_q.size() > 2, "R7 earlier copy unfinished", 32'(exp_q.size()), 32'h3);
         while (core_hold) @(negedge clk);
         chk(exp_q.size() == 0, "R7 writes outstanding", 32'(exp_q.size()), 32'h0);
         chk(done_cnt == d0 + 2, "R7 both copies done", 32'(done_cnt), 32'(d0 + 2));
      end

      // R9 zero count
      begin
         int r0, d0;
         r0 = req_cycles; d0 = done_cnt;
         tos_val = 32'h010; nos_val = 32'h210;
         send(8'h0F); send(8'h08);
         repeat (6) @(negedge clk);
         chk(req_cycles == r0, "R9 zero count requests", 32'(req_cycles), 32'(r0));
         chk(done_cnt == d0, "R9 zero count done", 32'(done_cnt), 32'(d0));
         chk(core_hold == 1'b0, "R9 hold after zero count", 32'(core_hold), 32'h0);
      end

      // R11 unknown extended opcode skips prefix-like parameters
      begin
         int r0, s0;
         r0 = req_cycles; s0 = stat_seen;
         send(8'h0F); send(8'h13);
         send(8'h0F); send(8'h08); send(8'h0F); send(8'h00);
         repeat (6) @(negedge clk);
         chk(req_cycles == r0, "R11 unknown opcode requests", 32'(req_cycles), 32'(r0));
         chk(stat_seen == s0, "R11 unknown opcode status", 32'(stat_seen), 32'(s0));
      end
      blocking(32'h020, 32'h240, 1, 2'b01, "R11 decoder still in step");

      // R4 final memory image
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 256; i++) if (mem[i] !== ref_m[i]) bad++;
         chk(bad == 0, "R4 memory image", 32'(bad), 32'h0);
      end
      finish_run();
   end

endmodule